// File: doc/BRIEF.md
# Schedule Base Time Aligner

This block takes a requested start time for a periodic gate schedule and pushes it forward by a whole number of schedule cycles so that the schedule starts a safe distance in the future. A request carries the present time, the requested base time and the cycle length. The block answers with an adjusted base time and a one-cycle completion pulse. Times are unsigned nanosecond counts and the cycle length is a narrower unsigned count.

The safe point, called the threshold here, is the present time plus two cycle lengths. A requested time that already reaches the threshold passes through untouched. An earlier requested time is advanced by the smallest whole number of cycles that brings it to or past the threshold. The block finds that number without a divider. It first grows a power-of-two step until one step spans the remaining distance. It then walks the step sizes downward, one trial addition per clock. A trial is kept only while the running value stays below the threshold. One extra cycle at the end lifts the value over the threshold.

Times are assumed small enough that the threshold plus one cycle does not wrap the time width.

Top module: `base_time_aligner`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `busy_o` and `err_o` are 0 and `base_o` is 0 until the first request completes.
- R2: When `base_i` is greater than `now_i + 2*cycle_i` and `cycle_i` is nonzero, `base_o` equals `base_i`. `err_o` is 0 and `done_o` rises on the clock edge that accepts `start_i`.
- R3: When `base_i` equals `now_i + 2*cycle_i` exactly, `base_o` equals `base_i` unchanged.
- R4: When `base_i` is below the threshold, `base_o` equals `base_i + N*cycle_i`, where N is the smallest integer for which the sum is at least the threshold. This includes the case where the sum lands exactly on the threshold.
- R5: Every adjusted result lies at or above the threshold and less than one cycle length above it.
- R6: A `cycle_i` of zero completes on the accepting edge with `err_o` = 1 and `base_o` = `base_i`. `err_o` returns to 0 on the next accepted request with a nonzero cycle.
- R7: `done_o` is high for exactly one clock per request. `busy_o` is high while a search is running and never together with `done_o`. A `start_i` seen while busy is ignored and does not change the result of the running request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request strobe, taken when idle |
| now_i | input | TIME_W | Present time in ns |
| base_i | input | TIME_W | Requested base time in ns |
| cycle_i | input | CYC_W | Schedule cycle length in ns |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| err_o | output | 1 | Last request had a zero cycle length |
| base_o | output | TIME_W | Adjusted base time |

## Verification
The bench targets the threshold boundary from both sides. A requested time exactly on the threshold must pass through. A time one cycle short of landing on it must land on it exactly and not a whole cycle past it. A design that used a strict compare, or skipped the final single-cycle add, would be off by one cycle in these cases. Very long distances with a one-nanosecond cycle and the widest cycle value exercise the step-size cap and the carry out of the trial adder. A design that truncated either would return a result outside the one-cycle window. A zero cycle length and a second request arriving mid-search check the error path and the busy lock-out. Without the lock-out, the running result would be replaced by a corrupted one.

// File: rtl/bta_pkg.sv
package bta_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCALE  = 2'd1,
    ST_SEARCH = 2'd2
  } bta_state_e;
endpackage

// File: rtl/bta_rst_sync.sv
module bta_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bta_thresh.sv
module bta_thresh #(
  parameter int TIME_W = 64,
  parameter int CYC_W  = 32
) (
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] base_i,
  input  logic [CYC_W-1:0]  cycle_i,
  output logic [TIME_W-1:0] thr_o,
  output logic              reached_o
);
  localparam int PAD_W = TIME_W - CYC_W - 1;

  // threshold = now + 2 * cycle, doubling done as a shift
  assign thr_o     = now_i + {{PAD_W{1'b0}}, cycle_i, 1'b0};
  assign reached_o = (base_i >= thr_o);
endmodule

// File: rtl/bta_chunk.sv
module bta_chunk #(
  parameter int TIME_W = 64,
  parameter int CYC_W  = 32,
  parameter int K_W    = 6
) (
  input  logic [TIME_W-1:0] acc_i,
  input  logic [TIME_W-1:0] thr_i,
  input  logic [CYC_W-1:0]  cycle_i,
  input  logic [K_W-1:0]    k_i,
  output logic [TIME_W-1:0] trial_o,
  output logic              fits_o
);
  logic [TIME_W-1:0] chunk;
  logic [TIME_W-1:0] gap;

  // chunk = cycle * 2^k as a left shift
  assign chunk   = {{(TIME_W-CYC_W){1'b0}}, cycle_i} << k_i;
  assign gap     = thr_i - acc_i;
  // acc + chunk < thr, written without a carry-prone add
  assign fits_o  = (chunk < gap);
  assign trial_o = acc_i + chunk;
endmodule

// File: rtl/base_time_aligner.sv
module base_time_aligner
  import bta_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int CYC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] base_i,
  input  logic [CYC_W-1:0]  cycle_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [TIME_W-1:0] base_o
);
  localparam int            K_MAX_I = TIME_W - CYC_W;
  localparam int            K_W     = $clog2(K_MAX_I + 1);
  localparam logic [K_W-1:0] K_MAX  = K_W'(K_MAX_I);

  logic rst_sync_n;

  bta_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bta_state_e        st_q, st_d;
  logic [TIME_W-1:0] thr_q, thr_d;
  logic [TIME_W-1:0] acc_q, acc_d;
  logic [TIME_W-1:0] res_q, res_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [K_W-1:0]    k_q, k_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              adj_q, adj_d;
  logic              load_en, work_en, res_en;

  logic [TIME_W-1:0] thr_in;
  logic              reached_in;
  logic [TIME_W-1:0] trial;
  logic              fits;

  bta_thresh #(.TIME_W(TIME_W), .CYC_W(CYC_W)) u_thr (
    .now_i     (now_i),
    .base_i    (base_i),
    .cycle_i   (cycle_i),
    .thr_o     (thr_in),
    .reached_o (reached_in)
  );

  bta_chunk #(.TIME_W(TIME_W), .CYC_W(CYC_W), .K_W(K_W)) u_chunk (
    .acc_i   (acc_q),
    .thr_i   (thr_q),
    .cycle_i (cyc_q),
    .k_i     (k_q),
    .trial_o (trial),
    .fits_o  (fits)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    thr_d   = thr_q;
    acc_d   = acc_q;
    res_d   = res_q;
    cyc_d   = cyc_q;
    k_d     = k_q;
    err_d   = err_q;
    adj_d   = adj_q;
    done_d  = 1'b0;
    load_en = 1'b0;
    work_en = 1'b0;
    res_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load_en = 1'b1;
          thr_d   = thr_in;
          cyc_d   = cycle_i;
          acc_d   = base_i;
          k_d     = '0;
          err_d   = 1'b0;
          adj_d   = 1'b0;
          if (cycle_i == '0) begin
            err_d  = 1'b1;
            res_en = 1'b1;
            res_d  = base_i;
            done_d = 1'b1;
          end else if (reached_in) begin
            res_en = 1'b1;
            res_d  = base_i;
            done_d = 1'b1;
          end else begin
            st_d = ST_SCALE;
          end
        end
      end
      ST_SCALE: begin
        work_en = 1'b1;
        if (fits && (k_q != K_MAX)) k_d = k_q + 1'b1;
        else                        st_d = ST_SEARCH;
      end
      ST_SEARCH: begin
        work_en = 1'b1;
        if (fits) begin
          acc_d = trial;
        end else if (k_q == '0) begin
          res_en = 1'b1;
          res_d  = acc_q + {{(TIME_W-CYC_W){1'b0}}, cyc_q};
          adj_d  = 1'b1;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          k_d = k_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      thr_q  <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      cyc_q  <= '0;
      k_q    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      adj_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (load_en) begin
        thr_q <= thr_d;
        cyc_q <= cyc_d;
        err_q <= err_d;
      end
      if (load_en || work_en) begin
        acc_q <= acc_d;
        k_q   <= k_d;
      end
      if (res_en) begin
        res_q <= res_d;
        adj_q <= adj_d;
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
  assign base_o = res_q;

  // assertions
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(busy_o && done_o));

  assert_search_below_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |-> (acc_q < thr_q));

  assert_window_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && adj_q) |-> ((base_o >= thr_q) &&
      ((base_o - thr_q) < {{(TIME_W-CYC_W){1'b0}}, cyc_q})));

  assert_zero_cycle_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && err_o) |-> (cyc_q == '0));

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (!busy_o && !done_o && !err_o));
endmodule

// File: tb/base_time_aligner_tb.sv
module base_time_aligner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 8;
  localparam int WAIT_MAX   = 20000;
  localparam int WDOG_MAX   = 180000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] now_i = '0;
  logic [63:0] base_i = '0;
  logic [31:0] cycle_i = '0;
  logic        busy_o, done_o, err_o;
  logic [63:0] base_o;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;

  localparam logic [63:0] V_NOW [NVEC] = '{
    64'd1000, 64'd1000, 64'd1000, 64'd1000000007,
    64'h0000_1234_5678_9abc, 64'd500, 64'd10, 64'h4000_0000_0000_0000};
  localparam logic [63:0] V_BASE [NVEC] = '{
    64'd0, 64'd5000, 64'd1200, 64'd3,
    64'd17, 64'd499, 64'd0, 64'h3FFF_FFFF_FFFF_0000};
  localparam logic [31:0] V_CYC [NVEC] = '{
    32'd100, 32'd100, 32'd100, 32'd250000,
    32'd1, 32'hFFFF_FFFF, 32'd3, 32'd1000};

  base_time_aligner dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .now_i   (now_i),
    .base_i  (base_i),
    .cycle_i (cycle_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .base_o  (base_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt == WDOG_MAX) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc_cnt, WDOG_MAX);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] expect_base(input logic [63:0] n, input logic [63:0] b,
                                              input logic [31:0] c);
    logic [63:0] t, d, k;
    if (c == 0) return b;
    t = n + 2 * {32'd0, c};
    if (b >= t) return b;
    d = t - b;
    k = (d + {32'd0, c} - 1) / {32'd0, c};
    return b + k * {32'd0, c};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // issue a request, return result and the negedge count until done
  task automatic run_req(input logic [63:0] n, input logic [63:0] b, input logic [31:0] c,
                         output int lat);
    @(negedge clk);
    now_i = n; base_i = b; cycle_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < WAIT_MAX) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic [63:0] exp, thr;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {63'd0, busy_o}, 64'd0);
    check("R1 done in reset", {63'd0, done_o}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 err after reset", {63'd0, err_o}, 64'd0);
    check("R1 result after reset", base_o, 64'd0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      run_req(V_NOW[i], V_BASE[i], V_CYC[i], lat);
      exp = expect_base(V_NOW[i], V_BASE[i], V_CYC[i]);
      thr = V_NOW[i] + 2 * {32'd0, V_CYC[i]};
      check("R4 done seen", {63'd0, done_o}, 64'd1);
      check("R4 result", base_o, exp);
      check("R6 err clear", {63'd0, err_o}, 64'd0);
      if (V_BASE[i] >= thr) begin
        check("R2 R3 pass-through latency", 64'(lat), 64'd1);
      end else begin
        check("R5 window low", {63'd0, base_o >= thr}, 64'd1);
        check("R5 window high", {63'd0, (base_o - thr) < {32'd0, V_CYC[i]}}, 64'd1);
      end
      @(negedge clk);
      check("R7 done single pulse", {63'd0, done_o}, 64'd0);
    end

    // R4: one cycle short lands exactly on threshold
    run_req(64'd2000, 64'd2100, 32'd100, lat);
    check("R4 exact landing", base_o, 64'd2200);

    // R6: zero cycle
    run_req(64'd777, 64'd5, 32'd0, lat);
    check("R6 err set", {63'd0, err_o}, 64'd1);
    check("R6 result unchanged", base_o, 64'd5);
    check("R6 latency", 64'(lat), 64'd1);
    run_req(64'd1000, 64'd0, 32'd100, lat);
    check("R6 err cleared", {63'd0, err_o}, 64'd0);

    // R7: start ignored while busy
    @(negedge clk);
    now_i = 64'd1000; base_i = 64'd0; cycle_i = 32'd100; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R7 busy during search", {63'd0, busy_o}, 64'd1);
    now_i = 64'd9; base_i = 64'd9999; cycle_i = 32'd7; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < WAIT_MAX) begin
      @(negedge clk);
      lat++;
    end
    check("R7 busy request kept", base_o, 64'd1200);
    @(negedge clk);
    check("R7 idle after done", {63'd0, busy_o}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule